// File: doc/BRIEF.md
# Interrupt Remapping Entry Validator

The validator sits between the devices that signal interrupts by writing a message and the interrupt controller. Each request carries the 16-bit identity of the requester and a handle. The handle selects one 128-bit entry of a remapping table in memory. The block fetches that entry through a read port that answers after a variable latency.

It then decides whether the request may pass. The entry must be present. When the entry asks for it, the requester identity must equal the identity stored in the entry, optionally ignoring some low function bits. A passing request leaves as either:
- a normal interrupt message carrying vector, destination, destination mode, redirection hint, trigger mode and delivery mode, or
- a posted-delivery indication carrying only the vector.

A failing request is dropped. It is recorded in a single fault register unless the entry suppresses reporting. The register holds until software clears it, and any further fault while it is full sets an overflow flag.

Top module: `irq_remap_validator`

## Requirements
- R1: A request is accepted in a cycle with `req_valid` and `req_ready` both high. An in-range handle issues exactly one read with `mem_rd_en` high and `mem_rd_addr` equal to the handle, in that same cycle. `req_ready` then stays low until the read data arrives with `mem_rd_valid`, so no second read is issued meanwhile.
- R2: A handle at or above `TBL_ENTRIES` issues no read. In the cycle after acceptance it produces a fault with reason code 2, and this fault is always reported.
- R3: An entry whose present bit (bit 0) is 0 blocks the interrupt with reason code 1.
- R4: The validation type sits in entry bits 83:82. Types 0 and 2 skip the identity check. Type 1 requires the identities to match, and a mismatch blocks with reason code 3. Type 3 is reserved and always blocks with reason code 4. Reason priority is 1, then 4, then 3.
- R5: The qualifier sits in entry bits 81:80, and the expected identity in bits 79:64. Before the type-1 comparison, qualifier 1 ignores identity bit 2, qualifier 2 ignores bits 2:1, and qualifier 3 ignores bits 2:0.
- R6: An accepted entry without the posted bit drives `int_valid` for one cycle, in the cycle after `mem_rd_valid`. The outputs then carry these entry fields:

  | Output | Entry bits |
  |---|---|
  | vector | 23:16 |
  | destination | 63:32 |
  | destination mode (0 = physical) | 2 |
  | redirection hint | 3 |
  | trigger mode | 4 |
  | delivery mode (0 = fixed) | 7:5 |

- R7: An accepted entry with the posted bit (bit 15) set drives `post_valid` for one cycle with the vector from bits 23:16, and no `int_valid`.
- R8: When fault-processing-disable (bit 1) is set, a blocked interrupt produces no output and leaves the fault register unchanged.
- R9: A reported fault loads identity, handle and reason into the fault register and sets `flt_valid`, provided the register is empty or is being cleared in the same cycle. A fault that arrives while the register is full and not being cleared leaves the record unchanged and sets `flt_overflow`. A `flt_clear` pulse with no fault clears both flags.
- R10: After reset, `req_ready` is high and the `int_valid`, `post_valid`, `flt_valid`, `flt_overflow` and `mem_rd_en` outputs are low.
- R11: A `mem_rd_valid` pulse while no read is outstanding has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Interrupt request present |
| req_sid | input | 16 | Requester identity |
| req_handle | input | HANDLE_W | Remapping table index |
| req_ready | output | 1 | Block can accept a request |
| mem_rd_en | output | 1 | Table read request |
| mem_rd_addr | output | HANDLE_W | Table entry index to read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 128 | Table entry |
| int_valid | output | 1 | Remapped interrupt message strobe |
| int_vector | output | 8 | Interrupt vector |
| int_dest | output | 32 | Destination identifier |
| int_dest_mode | output | 1 | Destination mode, 0 physical |
| int_redir_hint | output | 1 | Redirection hint |
| int_trig_mode | output | 1 | Trigger mode |
| int_dlv_mode | output | 3 | Delivery mode, 0 fixed |
| post_valid | output | 1 | Posted-delivery strobe |
| post_vector | output | 8 | Vector for posted delivery |
| flt_clear | input | 1 | Clears fault record and overflow |
| flt_valid | output | 1 | Fault record held |
| flt_overflow | output | 1 | Fault seen while record full |
| flt_sid | output | 16 | Faulting requester identity |
| flt_handle | output | HANDLE_W | Faulting handle |
| flt_reason | output | 3 | Fault reason code |

## Verification
The assertions check, on every cycle, the properties that need no entry decoding:
- only one read is outstanding, and no read is issued while busy;
- an out-of-range handle faults in the next cycle when the record is empty;
- normal and posted strobes never coincide, and both follow read data;
- a held fault record stays stable until cleared, and overflow only appears with a valid record.

The remaining behaviours need chosen table contents and request patterns, so only the bench scenarios can show them:
- the mapping of entry fields onto the message;
- the qualifier masks and the mismatch cases they allow or reject;
- the reserved validation type, and silent blocking when reporting is disabled;
- a clear colliding with a new fault, and a stray read response.

// File: rtl/irq_remap_validator.sv
module irq_remap_validator #(
  parameter int HANDLE_W    = 16,
  parameter int TBL_ENTRIES = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [15:0]         req_sid,
  input  logic [HANDLE_W-1:0] req_handle,
  output logic                req_ready,
  output logic                mem_rd_en,
  output logic [HANDLE_W-1:0] mem_rd_addr,
  input  logic                mem_rd_valid,
  input  logic [127:0]        mem_rd_data,
  output logic                int_valid,
  output logic [7:0]          int_vector,
  output logic [31:0]         int_dest,
  output logic                int_dest_mode,
  output logic                int_redir_hint,
  output logic                int_trig_mode,
  output logic [2:0]          int_dlv_mode,
  output logic                post_valid,
  output logic [7:0]          post_vector,
  input  logic                flt_clear,
  output logic                flt_valid,
  output logic                flt_overflow,
  output logic [15:0]         flt_sid,
  output logic [HANDLE_W-1:0] flt_handle,
  output logic [2:0]          flt_reason
);
  localparam logic [HANDLE_W:0] LIMIT = (HANDLE_W+1)'(TBL_ENTRIES);
  localparam logic [2:0] RSN_ABSENT = 3'd1, RSN_RANGE = 3'd2, RSN_SID = 3'd3, RSN_TYPE = 3'd4;

  logic                busy;
  logic [15:0]         cur_sid;
  logic [HANDLE_W-1:0] cur_hdl;

  wire accept   = req_valid && !busy;
  wire in_range = {1'b0, req_handle} < LIMIT;
  assign req_ready   = !busy;
  assign mem_rd_en   = accept && in_range;
  assign mem_rd_addr = req_handle;

  wire        e_present = mem_rd_data[0];
  wire        e_fpd     = mem_rd_data[1];
  wire        e_posted  = mem_rd_data[15];
  wire [15:0] e_sid     = mem_rd_data[79:64];
  wire [1:0]  e_sq      = mem_rd_data[81:80];
  wire [1:0]  e_svt     = mem_rd_data[83:82];

  logic [15:0] cmp_mask;
  always_comb begin
    case (e_sq)
      2'd1:    cmp_mask = 16'hFFFB;
      2'd2:    cmp_mask = 16'hFFF9;
      2'd3:    cmp_mask = 16'hFFF8;
      default: cmp_mask = 16'hFFFF;
    endcase
  end

  wire sid_ok = ((cur_sid ^ e_sid) & cmp_mask) == 16'h0;

  logic [2:0] ent_reason;
  always_comb begin
    if (!e_present)                 ent_reason = RSN_ABSENT;
    else if (e_svt == 2'd3)         ent_reason = RSN_TYPE;
    else if (e_svt == 2'd1 && !sid_ok) ent_reason = RSN_SID;
    else                            ent_reason = 3'd0;
  end

  wire resolve = busy && mem_rd_valid;
  wire deliver = resolve && ent_reason == 3'd0;
  wire flt_evt = (accept && !in_range) || (resolve && ent_reason != 3'd0 && !e_fpd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy           <= 1'b0;
      cur_sid        <= '0;
      cur_hdl        <= '0;
      int_valid      <= 1'b0;
      post_valid     <= 1'b0;
      int_vector     <= '0;
      int_dest       <= '0;
      int_dest_mode  <= 1'b0;
      int_redir_hint <= 1'b0;
      int_trig_mode  <= 1'b0;
      int_dlv_mode   <= '0;
      post_vector    <= '0;
      flt_valid      <= 1'b0;
      flt_overflow   <= 1'b0;
      flt_sid        <= '0;
      flt_handle     <= '0;
      flt_reason     <= '0;
    end else begin
      int_valid  <= deliver && !e_posted;
      post_valid <= deliver && e_posted;
      if (mem_rd_en) begin
        busy    <= 1'b1;
        cur_sid <= req_sid;
        cur_hdl <= req_handle;
      end else if (resolve) begin
        busy <= 1'b0;
      end
      if (deliver) begin
        int_vector     <= mem_rd_data[23:16];
        int_dest       <= mem_rd_data[63:32];
        int_dest_mode  <= mem_rd_data[2];
        int_redir_hint <= mem_rd_data[3];
        int_trig_mode  <= mem_rd_data[4];
        int_dlv_mode   <= mem_rd_data[7:5];
        post_vector    <= mem_rd_data[23:16];
      end
      if (flt_evt) begin
        if (flt_valid && !flt_clear) begin
          flt_overflow <= 1'b1;
        end else begin
          flt_valid    <= 1'b1;
          flt_overflow <= 1'b0;
          flt_sid      <= resolve ? cur_sid : req_sid;
          flt_handle   <= resolve ? cur_hdl : req_handle;
          flt_reason   <= resolve ? ent_reason : RSN_RANGE;
        end
      end else if (flt_clear) begin
        flt_valid    <= 1'b0;
        flt_overflow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_remap_validator_chk.sv
module irq_remap_validator_chk #(
  parameter int HANDLE_W    = 16,
  parameter int TBL_ENTRIES = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [HANDLE_W-1:0] req_handle,
  input logic                req_ready,
  input logic                mem_rd_en,
  input logic                mem_rd_valid,
  input logic                int_valid,
  input logic                post_valid,
  input logic                flt_clear,
  input logic                flt_valid,
  input logic                flt_overflow,
  input logic [15:0]         flt_sid,
  input logic [HANDLE_W-1:0] flt_handle,
  input logic [2:0]          flt_reason
);
  localparam logic [HANDLE_W:0] LIMIT = (HANDLE_W+1)'(TBL_ENTRIES);

  p_single_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  p_busy_no_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !mem_rd_en);
  p_range_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && {1'b0, req_handle} >= LIMIT && !flt_valid)
      |=> (flt_valid && flt_reason == 3'd2));
  p_after_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid || post_valid) |-> $past(mem_rd_valid));
  p_one_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_valid && post_valid));
  p_record_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clear) |=> (flt_valid && $stable(flt_sid)
      && $stable(flt_handle) && $stable(flt_reason)));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_overflow |-> flt_valid);
endmodule

bind irq_remap_validator irq_remap_validator_chk #(
  .HANDLE_W(HANDLE_W), .TBL_ENTRIES(TBL_ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_handle(req_handle),
  .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_rd_valid(mem_rd_valid),
  .int_valid(int_valid), .post_valid(post_valid), .flt_clear(flt_clear),
  .flt_valid(flt_valid), .flt_overflow(flt_overflow), .flt_sid(flt_sid),
  .flt_handle(flt_handle), .flt_reason(flt_reason)
);

// File: tb/irq_remap_validator_tb.sv
module irq_remap_validator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 16;
  localparam int TBL = 256;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, flt_clear = 0;
  logic [15:0] req_sid = 0;
  logic [HW-1:0] req_handle = 0;
  logic req_ready, mem_rd_en;
  logic [HW-1:0] mem_rd_addr;
  logic mem_rd_valid;
  logic [127:0] mem_rd_data;
  logic int_valid, int_dest_mode, int_redir_hint, int_trig_mode, post_valid;
  logic [7:0] int_vector, post_vector;
  logic [31:0] int_dest;
  logic [2:0] int_dlv_mode, flt_reason;
  logic flt_valid, flt_overflow;
  logic [15:0] flt_sid;
  logic [HW-1:0] flt_handle;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_remap_validator #(.HANDLE_W(HW), .TBL_ENTRIES(TBL)) u_dut (.*);

  int n_chk = 0, n_fail = 0, n_int = 0, n_post = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [127:0] mk(bit p, bit fpd, bit dm, bit rh, bit tm, int dlv, int vec,
                                      longint dest, bit posted, int sid, int sq, int svt);
    logic [127:0] e = '0;
    e[0] = p; e[1] = fpd; e[2] = dm; e[3] = rh; e[4] = tm; e[7:5] = 3'(dlv);
    e[15] = posted; e[23:16] = 8'(vec); e[63:32] = 32'(dest);
    e[79:64] = 16'(sid); e[81:80] = 2'(sq); e[83:82] = 2'(svt);
    return e;
  endfunction

  // table memory with variable latency
  logic [127:0] tbl [TBL];
  logic [HW-1:0] m_addr;
  int m_cnt, lat = 1;
  bit inject = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_valid <= 0; mem_rd_data <= '0; m_cnt <= 0; m_addr <= '0;
    end else begin
      mem_rd_valid <= 0;
      if (inject) begin
        mem_rd_valid <= 1; mem_rd_data <= tbl[0];
      end else if (mem_rd_en) begin
        m_addr <= mem_rd_addr; m_cnt <= lat;
      end else if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin mem_rd_valid <= 1; mem_rd_data <= tbl[m_addr]; end
      end
    end
  end

  // reference model
  function automatic int judge(logic [127:0] e, logic [15:0] sid);
    int keep = 16'hFFFF;
    for (int b = 0; b < int'(e[81:80]); b++) keep = keep & ~(1 << (2 - b));
    if (e[0] == 0) return 1;
    if (e[83:82] == 3) return 4;
    if (e[83:82] == 1 && ((int'(sid) ^ int'(e[79:64])) & keep) != 0) return 3;
    return 0;
  endfunction

  bit m_busy, x_int, x_post, x_fv, x_fo;
  logic [15:0] m_sid, x_fsid;
  logic [HW-1:0] m_hdl, x_fhdl;
  logic [127:0] x_ent;
  int x_frsn;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; x_int <= 0; x_post <= 0; x_fv <= 0; x_fo <= 0;
      m_sid <= 0; m_hdl <= 0; x_fsid <= 0; x_fhdl <= 0; x_frsn <= 0; x_ent <= '0;
    end else begin
      bit ev; int er; logic [15:0] es; logic [HW-1:0] eh;
      ev = 0; er = 0; es = 0; eh = 0;
      x_int <= 0; x_post <= 0;
      if (!m_busy && req_valid) begin
        if (int'(req_handle) >= TBL) begin ev = 1; er = 2; es = req_sid; eh = req_handle; end
        else begin m_busy <= 1; m_sid <= req_sid; m_hdl <= req_handle; end
      end else if (m_busy && mem_rd_valid) begin
        m_busy <= 0;
        er = judge(mem_rd_data, m_sid);
        if (er == 0) begin
          x_ent <= mem_rd_data;
          if (mem_rd_data[15]) x_post <= 1; else x_int <= 1;
        end else if (!mem_rd_data[1]) begin
          ev = 1; es = m_sid; eh = m_hdl;
        end
      end
      if (ev && x_fv && !flt_clear) x_fo <= 1;
      else if (ev) begin x_fv <= 1; x_fo <= 0; x_fsid <= es; x_fhdl <= eh; x_frsn <= er; end
      else if (flt_clear) begin x_fv <= 0; x_fo <= 0; end
    end
  end

  // compare every clock
  always @(negedge clk) if (rst_n && !finished) begin
    bit xen;
    xen = !m_busy && req_valid && int'(req_handle) < TBL;
    chk(req_ready == !m_busy, "R1 req_ready", req_ready, !m_busy);
    chk(mem_rd_en == xen, "R1 mem_rd_en", mem_rd_en, xen);
    if (xen) chk(mem_rd_addr == req_handle, "R1 mem_rd_addr", mem_rd_addr, req_handle);
    chk(int_valid == x_int, "R6 int_valid", int_valid, x_int);
    chk(post_valid == x_post, "R7 post_valid", post_valid, x_post);
    if (x_int && int_valid) begin
      chk(int_vector == x_ent[23:16], "R6 vector", int_vector, x_ent[23:16]);
      chk(int_dest == x_ent[63:32], "R6 dest", int_dest, x_ent[63:32]);
      chk({int_dest_mode, int_redir_hint, int_trig_mode, int_dlv_mode} == {x_ent[2], x_ent[3], x_ent[4], x_ent[7:5]},
          "R6 modes", {int_dest_mode, int_redir_hint, int_trig_mode, int_dlv_mode},
          {x_ent[2], x_ent[3], x_ent[4], x_ent[7:5]});
    end
    if (x_post && post_valid) chk(post_vector == x_ent[23:16], "R7 post_vector", post_vector, x_ent[23:16]);
    chk(flt_valid == x_fv, "R9 flt_valid", flt_valid, x_fv);
    chk(flt_overflow == x_fo, "R9 flt_overflow", flt_overflow, x_fo);
    if (x_fv && flt_valid)
      chk({flt_sid, flt_handle, flt_reason} == {x_fsid, x_fhdl, 3'(x_frsn)}, "R9 record",
          {flt_sid, flt_handle, flt_reason}, {x_fsid, x_fhdl, 3'(x_frsn)});
    if (int_valid) n_int++;
    if (post_valid) n_post++;
  end

  task automatic send(input int sid, input int hdl);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_sid = 16'(sid); req_handle = HW'(hdl);
    @(negedge clk);
    req_valid = 0;
    repeat (7) @(negedge clk);
  endtask

  task automatic clear_fault();
    @(negedge clk); flt_clear = 1;
    @(negedge clk); flt_clear = 0;
  endtask

  task automatic exp_fault(input string tag, input int rsn);
    chk(flt_valid == 1 && int'(flt_reason) == rsn, tag, {flt_valid, flt_reason}, {1'b1, 3'(rsn)});
  endtask

  task automatic exp_pass(input string tag, input int i0, input int p0);
    chk(n_int - i0 + n_post - p0 == 1 && !flt_valid, tag, n_int - i0 + n_post - p0, 1);
  endtask

  initial begin
    for (int i = 0; i < TBL; i++) tbl[i] = '0;
    tbl[0]  = mk(1,0,0,0,0,0,8'h41,32'h12345678,0,0,0,0);
    tbl[1]  = mk(1,0,1,1,1,1,8'h52,32'hCAFE0001,0,0,0,0);
    tbl[2]  = mk(1,0,0,0,0,0,8'h63,32'h0,1,0,0,0);
    tbl[3]  = mk(0,0,0,0,0,0,8'h70,32'h0,0,0,0,0);
    tbl[4]  = mk(0,1,0,0,0,0,8'h71,32'h0,0,0,0,0);
    tbl[5]  = mk(1,0,0,0,0,0,8'h80,32'h5,0,16'h0310,0,1);
    tbl[6]  = mk(1,0,0,0,0,0,8'h81,32'h6,0,16'h0318,1,1);
    tbl[7]  = mk(1,0,0,0,0,0,8'h82,32'h7,0,16'h0320,2,1);
    tbl[8]  = mk(1,0,0,0,0,0,8'h83,32'h8,0,16'h0330,3,1);
    tbl[9]  = mk(1,0,0,0,0,2,8'h84,32'h9,0,16'h0400,0,2);
    tbl[10] = mk(1,0,0,0,0,0,8'h85,32'hA,0,16'h0500,0,3);
    tbl[11] = mk(1,1,0,0,0,0,8'h86,32'hB,0,16'h0600,0,1);
    tbl[12] = mk(1,0,0,0,0,0,8'h87,32'hC,1,16'h0700,0,1);
    repeat (3) @(negedge clk);
    chk(req_ready && !int_valid && !post_valid && !flt_valid && !flt_overflow && !mem_rd_en,
        "R10 reset state", {req_ready, int_valid, post_valid, flt_valid, flt_overflow, mem_rd_en}, 6'b100000);
    rst_n = 1;
    begin int i0, p0;
      i0 = n_int; p0 = n_post; send(16'h0100, 0); exp_pass("R6 fixed physical", i0, p0);
      lat = 3;
      i0 = n_int; p0 = n_post; send(16'h0100, 1); exp_pass("R6 logical level", i0, p0);
      lat = 2;
      i0 = n_int; p0 = n_post; send(16'h0100, 2); chk(n_post - p0 == 1 && n_int == i0, "R7 posted", n_post - p0, 1);
      send(16'h0101, 3); exp_fault("R3 not present", 1); clear_fault();
      send(16'h0101, 4); chk(!flt_valid, "R8 fpd silent", flt_valid, 0);
      send(16'h0102, 300); exp_fault("R2 out of range", 2); clear_fault();
      i0 = n_int; p0 = n_post; send(16'h0310, 5); exp_pass("R4 type1 match", i0, p0);
      send(16'h0311, 5); exp_fault("R4 type1 mismatch", 3); clear_fault();
      i0 = n_int; p0 = n_post; send(16'h031C, 6); exp_pass("R5 qual1 match", i0, p0);
      send(16'h031A, 6); exp_fault("R5 qual1 mismatch", 3); clear_fault();
      i0 = n_int; p0 = n_post; send(16'h0326, 7); exp_pass("R5 qual2 match", i0, p0);
      send(16'h0329, 7); exp_fault("R5 qual2 mismatch", 3); clear_fault();
      i0 = n_int; p0 = n_post; send(16'h0337, 8); exp_pass("R5 qual3 match", i0, p0);
      send(16'h0338, 8); exp_fault("R5 qual3 mismatch", 3); clear_fault();
      i0 = n_int; p0 = n_post; send(16'hBEEF, 9); exp_pass("R4 type2 skip", i0, p0);
      i0 = n_int; p0 = n_post; send(16'hBEEF, 0); exp_pass("R4 type0 skip", i0, p0);
      send(16'h0500, 10); exp_fault("R4 reserved type", 4); clear_fault();
      send(16'h0601, 11); chk(!flt_valid, "R8 fpd mismatch silent", flt_valid, 0);
      send(16'h0701, 12); exp_fault("R7 posted still validated", 3);
      send(16'h0702, 3);
      chk(flt_overflow && flt_reason == 3 && flt_sid == 16'h0701, "R9 overflow keeps first",
          {flt_overflow, flt_reason}, {1'b1, 3'd3});
      clear_fault();
      chk(!flt_valid && !flt_overflow, "R9 clear", {flt_valid, flt_overflow}, 0);
      send(16'h0801, 3);
      @(negedge clk); req_valid = 1; req_sid = 16'h0902; req_handle = HW'(999); flt_clear = 1;
      @(negedge clk); req_valid = 0; flt_clear = 0;
      chk(flt_valid && !flt_overflow && flt_reason == 2 && flt_sid == 16'h0902, "R9 clear with new fault",
          {flt_valid, flt_overflow, flt_reason}, {1'b1, 1'b0, 3'd2});
      clear_fault();
      i0 = n_int; p0 = n_post;
      @(negedge clk); inject = 1; @(negedge clk); inject = 0;
      repeat (3) @(negedge clk);
      chk(n_int == i0 && n_post == p0 && !flt_valid && req_ready, "R11 stray data ignored", n_int - i0, 0);
      lat = 1;
      i0 = n_int; p0 = n_post; send(16'h0100, 0); exp_pass("R1 fetch after stray", i0, p0);
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule